// File: doc/BRIEF.md
# Dual-Line Serial Result Shifter

This block is the serial read port of an eight-channel sampling converter. When the converter finishes a conversion, its conversion-done (BUSY) signal falls. On that falling edge the block captures the whole set of channel results into a bank of registers. A host then reads the results over two serial data lines, using a chip-select (active low) and a serial clock that the host supplies.

Both lines shift their results MSB first, 16 bits per result. Line A starts at channel 1 and counts upward. Line B starts at channel 5 and counts upward, wrapping from channel 8 to channel 1.

- **Two lines, 64 clocks:** a host using both lines collects all eight results in 64 clocks.
- **One line, 128 clocks:** a host using only line A gets channels 1 to 8 in ascending order.
- **Framing:** chip-select may stay low for the whole read, or it may be pulsed once per 16-clock result.

A first-data flag goes high while channel 1 is being shifted on line A. The block is written for a fast system clock. The serial clock, chip-select and BUSY are sampled as ordinary synchronous inputs, and their edges are detected inside the block. Tri-state is modelled by a separate output-enable signal.

Top module: `srs_dual_line_shifter`

## Requirements
- R1: On a BUSY falling edge the block captures all eight results and restarts reading at channel 1 on line A and channel 5 on line B. If chip-select is low at that moment, the first-data flag is set one clock later.
- R2: While chip-select is high, `dout_oe_o` and `first_o` are low one clock later. Whenever `dout_oe_o` is low, both data lines read 0.
- R3: One clock after a chip-select falling edge, `dout_oe_o` is high and each line presents bit 15 (the MSB) of its current result.
- R4: Each serial-clock rising edge while chip-select is low moves both lines to the next lower bit, one clock later. The 16th rising edge of a result presents the MSB of the next result.
- R5: In a continuous 64-clock read, line A delivers channels 1, 2, 3, 4 and line B delivers channels 5, 6, 7, 8.
- R6: In a continuous 128-clock read, line A delivers channels 1 to 8 in ascending order. Line B delivers 5, 6, 7, 8, 1, 2, 3, 4.
- R7: When chip-select is pulsed once per 16-clock result, the channel position carries across the pulses. A new falling edge restarts the current result at its MSB.
- R8: The first-data flag goes high on a chip-select falling edge when channel 1 is current on line A. It stays high through the 16th rising edge and goes low after the following serial-clock falling edge. It is never high while line B carries channel 1.
- R9: After eight results have been shifted, both lines output 0 until the next BUSY falling edge.
- R10: Serial-clock edges while chip-select is high have no effect: the next read starts at the same channel and bit.
- R11: After reset, all outputs are 0 and the result bank holds zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n_i | input | 1 | Chip-select from the host, active low |
| sclk_i | input | 1 | Serial clock from the host, sampled by clk |
| busy_i | input | 1 | Conversion-busy; its falling edge loads new results |
| results_i | input | 128 | Channel results, channel c in bits [16c+15:16c] (channel 1 at c=0) |
| dout_a_o | output | 1 | Serial data, line A |
| dout_b_o | output | 1 | Serial data, line B |
| dout_oe_o | output | 1 | Output enable for both data lines (low = high impedance) |
| first_o | output | 1 | First-data flag (channel 1 current on line A) |

## Verification
The assertions assume that chip-select, the serial clock and BUSY are already synchronous to `clk`. They also assume that each input holds a level for at least one clock, so that every edge is seen exactly once. The assertions do not assume that a serial-clock edge and a BUSY edge can share a cycle.

The stimulus meets these assumptions. Every input changes only on a falling edge of `clk` and holds each level for at least two clocks. BUSY is pulsed only while chip-select is high, or between serial-clock edges.

// File: rtl/srs_pkg.sv
package srs_pkg;

    // Edge and level events derived from the sampled host and converter inputs.
    typedef struct packed {
        logic cs_fall;
        logic cs_low;
        logic sclk_rise;
        logic sclk_fall;
        logic busy_fall;
    } srs_evt_t;

endpackage

// File: rtl/srs_edge_sense.sv
module srs_edge_sense
    import srs_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cs_n_i,
    input  logic     sclk_i,
    input  logic     busy_i,
    output srs_evt_t evt_o
);

    typedef struct packed {
        logic cs_n;
        logic sclk;
        logic busy;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d.cs_n = cs_n_i;
        smp_d.sclk = sclk_i;
        smp_d.busy = busy_i;

        evt_o.cs_fall   = smp_q.cs_n & ~cs_n_i;
        evt_o.cs_low    = ~cs_n_i;
        evt_o.sclk_rise = ~smp_q.sclk & sclk_i;
        evt_o.sclk_fall = smp_q.sclk & ~sclk_i;
        evt_o.busy_fall = smp_q.busy & ~busy_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q.cs_n <= 1'b1;
            smp_q.sclk <= 1'b0;
            smp_q.busy <= 1'b0;
        end else begin
            smp_q <= smp_d;
        end
    end

endmodule

// File: rtl/srs_result_bank.sv
module srs_result_bank #(
    parameter int N_CH  = 8,
    parameter int RES_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_i,
    input  logic [N_CH*RES_W-1:0] results_i,
    output logic [N_CH*RES_W-1:0] bank_o
);

    for (genvar c = 0; c < N_CH; c++) begin : g_slot
        logic [RES_W-1:0] slot_d, slot_q;

        always_comb begin
            slot_d = slot_q;
            if (load_i) begin
                slot_d = results_i[c*RES_W +: RES_W];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else begin
                slot_q <= slot_d;
            end
        end

        assign bank_o[c*RES_W +: RES_W] = slot_q;
    end

endmodule

// File: rtl/srs_read_seq.sv
module srs_read_seq
    import srs_pkg::*;
#(
    parameter int N_CH  = 8,
    parameter int RES_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  srs_evt_t              evt_i,
    input  logic [N_CH*RES_W-1:0] bank_i,
    input  logic [N_CH*RES_W-1:0] results_i,
    output logic                  dout_a_o,
    output logic                  dout_b_o,
    output logic                  dout_oe_o,
    output logic                  first_o
);

    localparam int CW   = $clog2(N_CH);
    localparam int WW   = CW + 1;
    localparam int BW   = $clog2(RES_W);
    localparam logic [WW-1:0] WORDS    = WW'(N_CH);
    localparam logic [BW-1:0] LAST_BIT = BW'(RES_W - 1);
    localparam logic [CW-1:0] HALF     = CW'(N_CH / 2);

    typedef struct packed {
        logic [WW-1:0] wcnt;   // results already completed on each line
        logic [BW-1:0] bcnt;   // bits already shifted of the current result
        logic          flag;   // channel 1 current on line A
        logic          oe;
        logic          da;
        logic          db;
        logic          first;
    } seq_t;

    seq_t st_d, st_q;

    logic [N_CH*RES_W-1:0] src;
    logic [RES_W-1:0]      words [N_CH];
    logic [CW-1:0]         ch_a;
    logic [CW-1:0]         ch_b;
    logic [BW-1:0]         bit_idx;
    logic                  live;

    always_comb begin
        st_d = st_q;
        src  = evt_i.busy_fall ? results_i : bank_i;

        for (int k = 0; k < N_CH; k++) begin
            words[k] = src[k*RES_W +: RES_W];
        end

        if (evt_i.busy_fall) begin
            st_d.wcnt = '0;
            st_d.bcnt = '0;
            st_d.flag = evt_i.cs_low;
        end else if (evt_i.cs_fall) begin
            st_d.bcnt = '0;
            st_d.flag = (st_q.wcnt == '0);
        end else if (evt_i.cs_low) begin
            if (evt_i.sclk_rise) begin
                if (st_q.bcnt == LAST_BIT) begin
                    st_d.bcnt = '0;
                    if (st_q.wcnt < WORDS) begin
                        st_d.wcnt = st_q.wcnt + 1'b1;
                    end
                end else begin
                    st_d.bcnt = st_q.bcnt + 1'b1;
                end
            end
            if (evt_i.sclk_fall && st_q.wcnt != '0) begin
                st_d.flag = 1'b0;
            end
        end

        ch_a    = st_d.wcnt[CW-1:0];
        ch_b    = ch_a + HALF;
        live    = st_d.wcnt < WORDS;
        bit_idx = LAST_BIT - st_d.bcnt;

        st_d.oe    = evt_i.cs_low;
        st_d.da    = st_d.oe & live & words[ch_a][bit_idx];
        st_d.db    = st_d.oe & live & words[ch_b][bit_idx];
        st_d.first = st_d.oe & st_d.flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout_a_o  = st_q.da;
    assign dout_b_o  = st_q.db;
    assign dout_oe_o = st_q.oe;
    assign first_o   = st_q.first;

endmodule

// File: rtl/srs_dual_line_shifter.sv
module srs_dual_line_shifter
    import srs_pkg::*;
#(
    parameter int N_CH  = 8,
    parameter int RES_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_n_i,
    input  logic                  sclk_i,
    input  logic                  busy_i,
    input  logic [N_CH*RES_W-1:0] results_i,
    output logic                  dout_a_o,
    output logic                  dout_b_o,
    output logic                  dout_oe_o,
    output logic                  first_o
);

    srs_evt_t              evt;
    logic [N_CH*RES_W-1:0] bank;

    srs_edge_sense i_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n_i (cs_n_i),
        .sclk_i (sclk_i),
        .busy_i (busy_i),
        .evt_o  (evt)
    );

    srs_result_bank #(.N_CH(N_CH), .RES_W(RES_W)) i_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (evt.busy_fall),
        .results_i (results_i),
        .bank_o    (bank)
    );

    srs_read_seq #(.N_CH(N_CH), .RES_W(RES_W)) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt),
        .bank_i    (bank),
        .results_i (results_i),
        .dout_a_o  (dout_a_o),
        .dout_b_o  (dout_b_o),
        .dout_oe_o (dout_oe_o),
        .first_o   (first_o)
    );

endmodule

// File: rtl/srs_dual_line_checker.sv
module srs_dual_line_checker (
    input logic clk,
    input logic rst_n,
    input logic cs_n_i,
    input logic sclk_i,
    input logic busy_i,
    input logic dout_a_o,
    input logic dout_b_o,
    input logic dout_oe_o,
    input logic first_o
);

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_i |=> (!dout_oe_o && !first_o)); // R2

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe_o |-> (!dout_a_o && !dout_b_o)); // R2

    AST_SELECT_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_i) |=> dout_oe_o); // R3

    AST_RELOAD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_i) && !cs_n_i) |=> first_o); // R1

    AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(first_o) |-> ((!$past(cs_n_i) && $past(cs_n_i, 2)) ||
                            (!$past(busy_i) && $past(busy_i, 2)))); // R8

    AST_SCLK_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_i && $changed(sclk_i)) |=> (!dout_a_o && !dout_b_o)); // R10

endmodule

bind srs_dual_line_shifter srs_dual_line_checker i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n_i    (cs_n_i),
    .sclk_i    (sclk_i),
    .busy_i    (busy_i),
    .dout_a_o  (dout_a_o),
    .dout_b_o  (dout_b_o),
    .dout_oe_o (dout_oe_o),
    .first_o   (first_o)
);

// File: tb/test_srs_dual_line_shifter.sv
`timescale 1ns/1ps
module test_srs_dual_line_shifter;

    localparam int N_CH  = 8;
    localparam int RES_W = 16;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  cs_n = 1'b1;
    logic                  sclk = 1'b0;
    logic                  busy = 1'b0;
    logic [N_CH*RES_W-1:0] results = '0;
    logic                  dout_a, dout_b, dout_oe, first;

    int n_chk = 0;
    int n_bad = 0;
    logic [RES_W-1:0] exp_res [N_CH];

    always #5 clk = ~clk;

    srs_dual_line_shifter #(.N_CH(N_CH), .RES_W(RES_W)) i_srs_dual_line_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_i    (cs_n),
        .sclk_i    (sclk),
        .busy_i    (busy),
        .results_i (results),
        .dout_a_o  (dout_a),
        .dout_b_o  (dout_b),
        .dout_oe_o (dout_oe),
        .first_o   (first)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [RES_W-1:0] pat(int seed, int c);
        return RES_W'(seed * 16'h1357 + c * 16'h2461 + 16'h8001);
    endfunction

    // Word k of a read: line A channel k, line B channel (k+4) mod 8, zeros after 8.
    function automatic logic [RES_W-1:0] exp_word(int k, bit line_b);
        if (k >= N_CH) return '0;
        return line_b ? exp_res[(k + N_CH/2) % N_CH] : exp_res[k];
    endfunction

    task automatic load(int seed);
        for (int c = 0; c < N_CH; c++) begin
            exp_res[c] = pat(seed, c);
            results[c*RES_W +: RES_W] = exp_res[c];
        end
        busy = 1'b1;
        tick(3);
        busy = 1'b0;
        tick(2);
        results = '0;
    endtask

    // Shifts one result with the host sampling before each rising edge.
    task automatic shift_word(int k, string req);
        logic [RES_W-1:0] wa, wb;
        logic fl_before, fl_after;
        fl_before = 1'b0;
        for (int b = 0; b < RES_W; b++) begin
            wa[RES_W-1-b] = dout_a;
            wb[RES_W-1-b] = dout_b;
            sclk = 1'b1;
            tick(2);
            if (b == RES_W - 1) fl_before = first;
            sclk = 1'b0;
            tick(2);
        end
        fl_after = first;
        chk({req, " line A word"}, 32'(wa), 32'(exp_word(k, 1'b0)));
        chk({req, " line B word"}, 32'(wb), 32'(exp_word(k, 1'b1)));
        chk("R8 flag through 16th rise", 32'(fl_before), 32'(k == 0));
        chk("R8 flag after 16th fall", 32'(fl_after), 32'd0);
    endtask

    task automatic read_frame(int first_k, int nwords, bit pulsed, string req);
        if (!pulsed) begin
            cs_n = 1'b0;
            tick(2);
            chk("R3 output enable after select", 32'(dout_oe), 32'd1);
        end
        for (int k = first_k; k < first_k + nwords; k++) begin
            if (pulsed) begin
                cs_n = 1'b0;
                tick(2);
                chk("R3 output enable after select", 32'(dout_oe), 32'd1);
                chk("R3 MSB on line A", 32'(dout_a), 32'(exp_word(k, 1'b0) >> (RES_W-1)));
            end
            shift_word(k, req);
            if (pulsed) begin
                cs_n = 1'b1;
                tick(2);
                chk("R2 released between pulses", 32'({dout_oe, first, dout_a, dout_b}), 32'd0);
            end
        end
        cs_n = 1'b1;
        tick(2);
        chk("R2 released after frame", 32'({dout_oe, first, dout_a, dout_b}), 32'd0);
    endtask

    task automatic t_reset();
        chk("R11 reset outputs", 32'({dout_oe, first, dout_a, dout_b}), 32'd0);
        cs_n = 1'b0;
        tick(2);
        chk("R11 bank zero line A", 32'(dout_a), 32'd0);
        chk("R11 bank zero line B", 32'(dout_b), 32'd0);
        cs_n = 1'b1;
        tick(2);
    endtask

    task automatic t_dual64();
        load(1);
        read_frame(0, 4, 1'b0, "R5 dual 64 clocks");
    endtask

    task automatic t_single128();
        load(2);
        read_frame(0, 9, 1'b0, "R6 single 128 clocks, R9 zeros after eight");
    endtask

    task automatic t_pulsed();
        load(3);
        read_frame(0, 8, 1'b1, "R7 per-result select pulses");
    endtask

    task automatic t_ignore();
        load(4);
        for (int i = 0; i < 20; i++) begin
            sclk = ~sclk;
            tick(2);
        end
        sclk = 1'b0;
        tick(2);
        chk("R10 idle clocks keep lines quiet", 32'({dout_a, dout_b}), 32'd0);
        read_frame(0, 2, 1'b1, "R10 idle clocks ignored");
    endtask

    task automatic t_reload();
        load(5);
        read_frame(0, 3, 1'b0, "R4 partial read");
        load(6);
        read_frame(0, 1, 1'b0, "R1 restart after reload");
        // reload while chip-select is low sets the flag
        cs_n = 1'b0;
        tick(2);
        for (int c = 0; c < N_CH; c++) results[c*RES_W +: RES_W] = pat(7, c);
        busy = 1'b1;
        tick(2);
        busy = 1'b0;
        tick(2);
        chk("R1 flag after reload with select low", 32'(first), 32'd1);
        chk("R1 new MSB line B", 32'(dout_b), 32'(pat(7, 4) >> (RES_W-1)));
        cs_n = 1'b1;
        tick(2);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_dual64();
        t_single128();
        t_pulsed();
        t_ignore();
        t_reload();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule